// File: doc/BRIEF.md
# Keyed watchdog timer

The block is a watchdog for a processor subsystem. A binary counter runs from reset and counts toward one of four terminal counts that a 2-bit period code selects. Software restarts the count by writing a restart key byte to a write-only command register. If the count reaches its terminal value first, the block raises a one-clock time-out pulse. When the reset-on-timeout bit is set, it also raises a one-clock system-reset request. The counter then starts again from zero.

A stray write cannot switch the watchdog off. Stopping it takes two steps: clear the enable bit in the mode register, then write a separate stop key to the command register. Clearing the enable bit alone leaves the watchdog counting. Writing the enable bit back to 1 restarts the watchdog with no key. The period and reset-on-timeout fields can only be changed while the watchdog is stopped.

Top module: `guard_wdt`

## Requirements
- R1: After reset the mode readback is 0x01: enable set, period code 00, reset-on-timeout clear. The counter starts at zero and runs, so the first time-out carries no reset request.
- R2: Writing 0x4E to the command register (sel_cmd_i=1) sets the counter to zero. The next time-out then comes a full period after that write.
- R3: Period codes 0 to 3 give time-outs every 2^(BASE_EXP+STEP_EXP*code) clocks, counted from the last restart.
- R4: A time-out is a one-clock pulse on tmo_o. The counter restarts from zero, so time-outs repeat every period while nothing restarts the count.
- R5: rst_req_o pulses in the same cycle as tmo_o when the reset-on-timeout bit (mode bit 3) is 1, and never when it is 0.
- R6: Writing 0xB1 to the command register while the enable bit is 0 stops the watchdog.
- R7: Clearing the enable bit (mode bit 0) without the stop key leaves the watchdog counting and timing out.
- R8: Writing the mode register with bit 0 set restarts a stopped watchdog from a zero count, with no key needed.
- R9: A command byte other than 0x4E, and 0xB1 written while the enable bit is 1, has no effect on the counter or on the mode readback.
- R10: Mode bits 2:1 (period) and bit 3 (reset-on-timeout) take a write only while the watchdog is stopped. While it runs, writes to them are dropped.
- R11: While stopped, the counter holds at zero and no time-out or reset request is produced.
- R12: mode_o shows the mode register as {4'b0, reset-on-timeout, period[1:0], enable}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| sel_cmd_i | input | 1 | 0 selects the mode register, 1 selects the command register |
| wdata_i | input | 8 | Write data |
| mode_o | output | 8 | Mode register readback |
| tmo_o | output | 1 | One-clock time-out pulse |
| rst_req_o | output | 1 | One-clock system-reset request |

## Verification
The assertions check five things on every cycle. The time-out is a single clock wide. A reset request only comes with a time-out. A stopped watchdog holds a zero count and never times out. The stop can only follow a cleared enable bit. The period field stays frozen while the watchdog runs. The exact cycle of each time-out depends on write history, so only the bench scenarios show it. Those scenarios cover the periods for each code, the restart key pushing a time-out later, ignored keys, the enable bit cleared without the stop key, and restart without a key. The bench predicts each time-out cycle and its reset flag from the requirements and queues it for the monitor.

// File: rtl/guard_wdt_pkg.sv
package guard_wdt_pkg;
  localparam int unsigned DW = 8;
  localparam logic [DW-1:0] KEY_KICK = 8'h4E;
  localparam logic [DW-1:0] KEY_HALT = 8'hB1;

  typedef struct packed {
    logic [3:0] rsvd;
    logic       rst_en;
    logic [1:0] period;
    logic       run_en;
  } mode_t;

  localparam mode_t MODE_RST = '{rsvd: 4'h0, rst_en: 1'b0, period: 2'b00, run_en: 1'b1};
endpackage

// File: rtl/guard_wdt_regs.sv
module guard_wdt_regs
  import guard_wdt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          sel_cmd_i,
  input  logic [DW-1:0] wdata_i,
  output mode_t         mode_o,
  output logic          halted_o,
  output logic          clr_o
);
  mode_t mode_q;
  logic  halted_q;
  logic  wr_mode, wr_cmd, kick, halt_key;

  assign wr_mode  = wr_i & ~sel_cmd_i;
  assign wr_cmd   = wr_i & sel_cmd_i;
  assign kick     = wr_cmd && (wdata_i == KEY_KICK);
  assign halt_key = wr_cmd && (wdata_i == KEY_HALT) && !mode_q.run_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RST;
      halted_q <= 1'b0;
    end else if (wr_mode) begin
      mode_q.run_en <= wdata_i[0];
      // settings only move while stopped
      if (halted_q) begin
        mode_q.period <= wdata_i[2:1];
        mode_q.rst_en <= wdata_i[3];
      end
      if (wdata_i[0]) halted_q <= 1'b0;
    end else if (halt_key) begin
      halted_q <= 1'b1;
    end
  end

  assign mode_o   = mode_q;
  assign halted_o = halted_q;
  assign clr_o    = kick | halt_key;

  AST_PERIOD_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(halted_q) |-> ($stable(mode_q.period) && $stable(mode_q.rst_en))); // R10
  AST_HALT_AFTER_EN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_q) |-> !$past(mode_q.run_en)); // R6
  AST_EN_RESUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mode && wdata_i[0]) |=> !halted_q); // R8
endmodule

// File: rtl/guard_wdt_counter.sv
module guard_wdt_counter #(
  parameter int unsigned BASE_EXP = 15,
  parameter int unsigned STEP_EXP = 2,
  localparam int unsigned CNT_W = BASE_EXP + 3 * STEP_EXP
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [1:0] period_i,
  input  logic       rst_en_i,
  output logic       tmo_o,
  output logic       rst_req_o
);
  logic [CNT_W-1:0] last_tab [4];
  logic [CNT_W-1:0] cnt_q;
  logic             hit, tmo_q, rreq_q;

  for (genvar g = 0; g < 4; g++) begin : g_term
    localparam int unsigned EXP_G = BASE_EXP + STEP_EXP * g;
    assign last_tab[g] = {CNT_W{1'b1}} >> (CNT_W - EXP_G);
  end

  assign hit = run_i && !clr_i && (cnt_q >= last_tab[period_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tmo_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      if (!run_i || clr_i || hit) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
      tmo_q  <= hit;
      rreq_q <= hit & rst_en_i;
    end
  end

  assign tmo_o     = tmo_q;
  assign rst_req_o = rreq_q;

  AST_TMO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |=> !tmo_q); // R4
  AST_RREQ_WITH_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rreq_q |-> tmo_q); // R5
  AST_KICK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R2
  AST_HALT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (cnt_q == '0)); // R11
  AST_HALT_NO_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && $past(!run_i)) |-> !tmo_q); // R11
endmodule

// File: rtl/guard_wdt.sv
module guard_wdt
  import guard_wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP = 15,
  parameter int unsigned STEP_EXP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          sel_cmd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mode_o,
  output logic          tmo_o,
  output logic          rst_req_o
);
  mode_t mode;
  logic  halted, clr;

  guard_wdt_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .sel_cmd_i (sel_cmd_i),
    .wdata_i   (wdata_i),
    .mode_o    (mode),
    .halted_o  (halted),
    .clr_o     (clr)
  );

  guard_wdt_counter #(
    .BASE_EXP (BASE_EXP),
    .STEP_EXP (STEP_EXP)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (!halted),
    .clr_i     (clr),
    .period_i  (mode.period),
    .rst_en_i  (mode.rst_en),
    .tmo_o     (tmo_o),
    .rst_req_o (rst_req_o)
  );

  assign mode_o = mode;

  AST_RREQ_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> mode_o[3]); // R5
  AST_NO_RREQ_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_o && !mode_o[3]) |-> !rst_req_o); // R5
endmodule

// File: tb/guard_wdt_test.sv
`timescale 1ns/1ps
module guard_wdt_test;
  localparam int unsigned BE = 4;
  localparam int unsigned SE = 1;
  localparam int T0 = 1 << BE;
  localparam int T1 = 1 << (BE + SE);
  localparam int T2 = 1 << (BE + 2 * SE);
  localparam int T3 = 1 << (BE + 3 * SE);

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic       sel_cmd_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] mode_o;
  logic       tmo_o, rst_req_o;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  int    q_cyc[$];
  bit    q_rst[$];
  string q_req[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  guard_wdt #(.BASE_EXP(BE), .STEP_EXP(SE)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .sel_cmd_i(sel_cmd_i),
    .wdata_i(wdata_i), .mode_o(mode_o), .tmo_o(tmo_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int c, input bit r, input string req);
    q_cyc.push_back(c);
    q_rst.push_back(r);
    q_req.push_back(req);
  endtask

  task automatic wr(input logic cmd, input logic [7:0] d, output int c);
    wr_i = 1'b1; sel_cmd_i = cmd; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
    c = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pops expected time-outs
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (rst_req_o && !tmo_o) chk("R5", "reset request without time-out", 1, 0);
      if (tmo_o) begin
        if (q_cyc.size() == 0) begin
          chk("R11", "unexpected time-out at cycle", cyc, 0);
        end else begin
          string rq;
          int ec;
          bit er;
          ec = q_cyc.pop_front(); er = q_rst.pop_front(); rq = q_req.pop_front();
          chk(rq, "time-out cycle", cyc, ec);
          chk(rq, "reset request", int'(rst_req_o), int'(er));
        end
      end else if (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
        string rq;
        int ec;
        ec = q_cyc.pop_front(); void'(q_rst.pop_front()); rq = q_req.pop_front();
        chk(rq, "missed time-out, now at cycle", cyc, ec);
      end
    end
  end

  initial begin
    int r0, c1, c2, c3, c4, c5, c6, c7, c8, c9, c10, c11, x;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    r0 = cyc;
    chk("R1", "mode after reset", int'(mode_o), 8'h01);
    chk("R1", "tmo after reset", int'(tmo_o), 0);
    chk("R1", "rst_req after reset", int'(rst_req_o), 0);
    push(r0 + T0, 1'b0, "R1");
    push(r0 + 2 * T0, 1'b0, "R4");
    wait_until(r0 + 2 * T0 + 4);

    wr(1'b1, 8'h4E, c1);
    wr(1'b0, 8'h00, c2);
    chk("R7", "mode after enable cleared", int'(mode_o), 8'h00);
    push(c1 + T0, 1'b0, "R7");
    wait_until(c1 + T0 + 4);
    wr(1'b1, 8'hB1, c3);
    chk("R6", "mode after stop key", int'(mode_o), 8'h00);
    wait_until(c3 + 5 * T0);

    wr(1'b0, 8'h0B, c4);
    chk("R8", "mode after restart", int'(mode_o), 8'h0B);
    for (int k = 1; k <= 4; k++) push(c4 + k * T1, 1'b1, "R3");
    wait_until(c4 + T1 + 8);
    wr(1'b0, 8'h07, c5);
    chk("R10", "settings locked while running", int'(mode_o), 8'h0B);
    wr(1'b1, 8'hB1, x);
    wr(1'b1, 8'h4D, x);
    wr(1'b1, 8'h00, x);
    chk("R9", "mode after ignored keys", int'(mode_o), 8'h0B);
    wait_until(c4 + 4 * T1 + 2);

    wr(1'b1, 8'h4E, c6);
    wait_until(c6 + T1 - 6);
    wr(1'b1, 8'h4E, c7);
    push(c7 + T1, 1'b1, "R2");
    wait_until(c7 + T1 + 2);

    wr(1'b0, 8'h0A, c8);
    chk("R12", "mode field layout", int'(mode_o), 8'h0A);
    wr(1'b1, 8'hB1, c9);
    wr(1'b0, 8'h0C, x);
    chk("R10", "settings written while stopped", int'(mode_o), 8'h0C);
    wait_until(c9 + 3 * T2);
    wr(1'b0, 8'h0D, c10);
    push(c10 + T2, 1'b1, "R3");
    wait_until(c10 + T2 + 2);

    wr(1'b0, 8'h0C, x);
    wr(1'b1, 8'hB1, x);
    wr(1'b0, 8'h07, c11);
    chk("R12", "mode code 11 no reset bit", int'(mode_o), 8'h07);
    push(c11 + T3, 1'b0, "R5");
    wait_until(c11 + T3 + 2);
    wr(1'b0, 8'h06, x);
    wr(1'b1, 8'hB1, x);
    wait_until(cyc + 3 * T3);
    chk("R4", "pending expected time-outs", q_cyc.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule